// File: doc/BRIEF.md
# Dual-Channel Fine-Adjust Pulse-Width D/A Generator

This block turns two digital codes into two pulse-width streams. After an external RC filter, each stream gives an analog level. One free-running up counter is shared by both channels and sets the timing. Each channel compares its own code against that counter.

Over one conversion period of 2^CNT_W time units, each output spends exactly "code" time units at its active level. That active time is not delivered as one long pulse. It is spread over many short basic cycles:

- Every basic cycle carries a base pulse, whose width comes from the upper bits of the code.
- Some basic cycles carry one extra time unit. The lower bits of the code decide how many.

This keeps the ripple frequency high while the full code resolution is kept in the average.

Software drives the block through a small word-wide register port. The port covers four things: a control word, one code register per channel, and the shared counter, which can be both read and loaded. A prescaler sets the length of one time unit to one or two system clocks. New codes are held back until the next period boundary, so no period ever mixes two codes.

Top module: `pwm_fine_dac`

## Requirements
- R1: A time unit T is one clock when control bit 0 (half_rate) is 0, and two clocks when it is 1. A conversion period lasts 2^CNT_W time units.
- R2: Over every conversion period, each enabled channel is at its active level for exactly code × T clocks. This holds for every code from 0 to 2^CNT_W−1.
- R3: The basic cycle is 2^SHORT_B T long when control bit 1 (long_cycle) is 0, and 2^LONG_B T long when it is 1.
  - Within a basic cycle, the active time is one run that starts at the beginning of the cycle.
  - The run is as long as the upper B bits of the code, plus the extra unit when it applies.
  - For a code whose upper bits are at least 1 and at most 2^B−2, the output therefore turns active once per basic cycle.
- R4: Basic cycle i, counted from 0 at the start of the period, receives the extra time unit when the bit-reversed value of i is below the code's lower CNT_W−B bits. So a code of 1 is active only in the first T of the period. A code of 2 is active at T = 0 and at T = 2^(CNT_W−1).
- R5: Control bit 2 (hi_active) selects the polarity. At 0 the active level is low; at 1 it is high. A channel whose enable is 0 holds its idle level, which is the inverse of the active level. The enable is bit 4 for channel 0 and bit 5 for channel 1.
- R6: While control bit 3 (run) is 0:
  - the counter holds at zero and reads back as zero;
  - both outputs sit at the idle level.
- R7: A code written during a period takes effect at the start of the next period. The period in progress finishes with the old code.
- R8: Address 3 holds the counter.
  - A read returns the count in bits 15:16−CNT_W, with zeros below.
  - A full-word write, while running, loads the shared counter for both channels. Counting continues from the loaded value.
- R9: A write to a code register or to the counter takes effect only when both byte enables are set. A write with only one byte enable set changes nothing.
- R10: The register map is: address 0 control (bits 5:0), address 1 channel 0 code, address 2 channel 1 code, address 3 counter. Codes are right-aligned. A read returns its data on the clock after it is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_be | input | 2 | Byte enables, bit 1 for the upper byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pwm_out | output | 2 | Pulse streams, bit c for channel c |

## Verification
The bench builds the block with CNT_W=10, SHORT_B=4 and LONG_B=6. With these values a conversion period is 1024 or 2048 clocks, and the basic cycle is 16 or 64 time units.

This makes it affordable to integrate whole periods for all eight combinations of time unit, cycle length and polarity. Each combination runs the extreme codes 0 and 1023, mixed codes, and codes that probe R3 and R4. That brings the bit-reversed spreading and the base-width split within reach of exact arithmetic checks. Mid-period code updates, counter loads and partial writes are checked at the ports.

// File: rtl/pwm_fine_dac_pkg.sv
package pwm_fine_dac_pkg;
  localparam int REG_W  = 16;
  localparam int NUM_CH = 2;

  // Control word. Bit 0 is half_rate, bit 5 is ch1_on.
  typedef struct packed {
    logic ch1_on;
    logic ch0_on;
    logic run;
    logic hi_active;
    logic long_cycle;
    logic half_rate;
  } ctl_t;

  typedef enum logic [1:0] {
    A_CTL  = 2'd0,
    A_DAT0 = 2'd1,
    A_DAT1 = 2'd2,
    A_CNT  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pwm_fine_dac_tick.sv
module pwm_fine_dac_tick (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic half_rate,
  output logic tick
);
  logic phase;

  always_ff @(posedge clk) begin
    if (rst || !run) phase <= 1'b0;
    else             phase <= !phase;
  end

  assign tick = run && (!half_rate || phase);

  // R1: at half rate a time unit spans two clocks
  assert_half_rate_R1: assert property (@(posedge clk) disable iff (rst)
    (run && half_rate && tick) |=> (!tick || !half_rate));
endmodule

// File: rtl/pwm_fine_dac_count.sv
module pwm_fine_dac_count #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (load)   cnt <= load_val;
    else if (tick)   cnt <= cnt + 1'b1;
  end

  assign wrap = tick && (&cnt);

  assert_hold_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));

  assert_step_R1: assert property (@(posedge clk) disable iff (rst)
    (run && !load && tick && !(&cnt)) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  assert_load_R8: assert property (@(posedge clk) disable iff (rst)
    (run && load) |=> (cnt == $past(load_val)));
endmodule

// File: rtl/pwm_fine_dac_chan.sv
module pwm_fine_dac_chan #(
  parameter int CNT_W   = 14,
  parameter int SHORT_B = 6,
  parameter int LONG_B  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic             refresh,
  input  logic [CNT_W-1:0] data_in,
  input  logic             long_cycle,
  input  logic             hi_active,
  input  logic             on,
  output logic             pwm
);
  localparam int NS = CNT_W - SHORT_B;  // number of index bits, short cycle
  localparam int NL = CNT_W - LONG_B;   // number of index bits, long cycle

  logic [CNT_W-1:0] data_live;

  logic [SHORT_B-1:0] pos_s, wid_s;
  logic [NS-1:0]      idx_s, rev_s, ext_s;
  logic [SHORT_B:0]   add_s;
  logic               act_s;

  logic [LONG_B-1:0]  pos_l, wid_l;
  logic [NL-1:0]      idx_l, rev_l, ext_l;
  logic [LONG_B:0]    add_l;
  logic               act_l;

  logic act;

  always_ff @(posedge clk) begin
    if (rst)          data_live <= '0;
    else if (refresh) data_live <= data_in;
  end

  always_comb begin
    pos_s = cnt[SHORT_B-1:0];
    idx_s = cnt[CNT_W-1:SHORT_B];
    wid_s = data_live[CNT_W-1:NS];
    ext_s = data_live[NS-1:0];
    for (int i = 0; i < NS; i++) rev_s[i] = idx_s[NS-1-i];
    add_s = {1'b0, wid_s} + {{SHORT_B{1'b0}}, (rev_s < ext_s)};
    act_s = ({1'b0, pos_s} < add_s);

    pos_l = cnt[LONG_B-1:0];
    idx_l = cnt[CNT_W-1:LONG_B];
    wid_l = data_live[CNT_W-1:NL];
    ext_l = data_live[NL-1:0];
    for (int i = 0; i < NL; i++) rev_l[i] = idx_l[NL-1-i];
    add_l = {1'b0, wid_l} + {{LONG_B{1'b0}}, (rev_l < ext_l)};
    act_l = ({1'b0, pos_l} < add_l);

    act = long_cycle ? act_l : act_s;
  end

  always_ff @(posedge clk) begin
    if (rst)     pwm <= 1'b1;
    else if (on) pwm <= hi_active ? act : !act;
    else         pwm <= !hi_active;
  end

  assert_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !on |=> (pwm == !$past(hi_active)));

  assert_live_stable_R7: assert property (@(posedge clk) disable iff (rst)
    !refresh |=> $stable(data_live));
endmodule

// File: rtl/pwm_fine_dac_regs.sv
module pwm_fine_dac_regs
  import pwm_fine_dac_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [1:0]                    bus_addr,
  input  logic [1:0]                    bus_be,
  input  logic [REG_W-1:0]              bus_wdata,
  input  logic [CNT_W-1:0]              cnt,
  output ctl_t                          ctl,
  output logic [NUM_CH-1:0][CNT_W-1:0]  dat,
  output logic                          cnt_load,
  output logic [CNT_W-1:0]              cnt_val,
  output logic [REG_W-1:0]              bus_rdata
);
  localparam int CNT_LSB = REG_W - CNT_W;

  reg_addr_e addr;
  logic      full_word;

  assign addr      = reg_addr_e'(bus_addr);
  assign full_word = (bus_be == 2'b11);
  assign cnt_load  = bus_wr && (addr == A_CNT) && full_word;
  assign cnt_val   = bus_wdata[REG_W-1:CNT_LSB];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl       <= '0;
      dat       <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr) begin
        case (addr)
          A_CTL:  if (bus_be[0]) ctl    <= ctl_t'(bus_wdata[$bits(ctl_t)-1:0]);
          A_DAT0: if (full_word) dat[0] <= bus_wdata[CNT_W-1:0];
          A_DAT1: if (full_word) dat[1] <= bus_wdata[CNT_W-1:0];
          default: ;
        endcase
      end
      if (bus_rd) begin
        case (addr)
          A_CTL:   bus_rdata <= REG_W'(ctl);
          A_DAT0:  bus_rdata <= REG_W'(dat[0]);
          A_DAT1:  bus_rdata <= REG_W'(dat[1]);
          default: bus_rdata <= REG_W'(cnt) << CNT_LSB;
        endcase
      end
    end
  end

  assert_partial_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && addr == A_DAT0 && !full_word) |=> $stable(dat[0]));

  assert_partial_ignored1_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && addr == A_DAT1 && !full_word) |=> $stable(dat[1]));
endmodule

// File: rtl/pwm_fine_dac.sv
module pwm_fine_dac
  import pwm_fine_dac_pkg::*;
#(
  parameter int CNT_W   = 14,
  parameter int SHORT_B = 6,
  parameter int LONG_B  = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [1:0]  bus_be,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic [1:0]  pwm_out
);
  ctl_t                         ctl;
  logic [NUM_CH-1:0][CNT_W-1:0] dat;
  logic                         cnt_load;
  logic [CNT_W-1:0]             cnt_val;
  logic [CNT_W-1:0]             cnt;
  logic                         tick;
  logic                         wrap;
  logic                         refresh;
  logic [NUM_CH-1:0]            ch_on;

  assign ch_on   = {ctl.ch1_on, ctl.ch0_on};
  assign refresh = !ctl.run || cnt_load || wrap;

  pwm_fine_dac_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata),
    .cnt(cnt), .ctl(ctl), .dat(dat),
    .cnt_load(cnt_load), .cnt_val(cnt_val), .bus_rdata(bus_rdata)
  );

  pwm_fine_dac_tick u_tick (
    .clk(clk), .rst(rst), .run(ctl.run),
    .half_rate(ctl.half_rate), .tick(tick)
  );

  pwm_fine_dac_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .run(ctl.run), .tick(tick),
    .load(cnt_load), .load_val(cnt_val), .cnt(cnt), .wrap(wrap)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_fine_dac_chan #(.CNT_W(CNT_W), .SHORT_B(SHORT_B), .LONG_B(LONG_B)) u_chan (
      .clk(clk), .rst(rst), .cnt(cnt), .refresh(refresh),
      .data_in(dat[c]), .long_cycle(ctl.long_cycle),
      .hi_active(ctl.hi_active), .on(ctl.run && ch_on[c]),
      .pwm(pwm_out[c])
    );
  end
endmodule

// File: tb/pwm_fine_dac_tb.sv
`timescale 1ns/1ps
module pwm_fine_dac_tb;
  localparam int W    = 10;
  localparam int SB   = 4;
  localparam int LB   = 6;
  localparam int MAXV = (1 << W) - 1;
  localparam int SH   = 16 - W;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0, bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  pwm_out;

  int  n_chk = 0, n_bad = 0;
  bit  done = 0;
  int  act_n [2];
  int  edg_n [2];
  bit  prev  [2];
  int  pos1, pos2;

  always #4 clk = ~clk;

  pwm_fine_dac #(.CNT_W(W), .SHORT_B(SB), .LONG_B(LB)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  task automatic chk(input bit ok, input string req, input int actv, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, actv, expv);
    end
  endtask

  task automatic bw(input logic [1:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic br(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    v = bus_rdata;
    bus_rd = 1'b0;
  endtask

  function automatic logic [15:0] ctlw(int cs, int cy, int os, int run, int ea, int eb);
    return 16'(cs | (cy << 1) | (os << 2) | (run << 3) | (ea << 4) | (eb << 5));
  endfunction

  task automatic run_cfg(int cs, int cy, int os, int ea, int eb, int da, int db);
    bw(2'd0, ctlw(cs, cy, os, 0, ea, eb), 2'b11);
    bw(2'd1, 16'(da), 2'b11);
    bw(2'd2, 16'(db), 2'b11);
    bw(2'd0, ctlw(cs, cy, os, 1, ea, eb), 2'b11);
    prev[0] = 0; prev[1] = 0;
  endtask

  // Integrates one conversion period; optional write at sample midk.
  task automatic meas(int cs, int os, bit mid, int midk, logic [1:0] ma, logic [15:0] md);
    int p;
    p = (1 << W) * (cs + 1);
    for (int c = 0; c < 2; c++) begin act_n[c] = 0; edg_n[c] = 0; end
    pos1 = -1; pos2 = -1;
    for (int k = 1; k <= p; k++) begin
      @(posedge clk); #1;
      for (int c = 0; c < 2; c++) begin
        bit a;
        a = (os != 0) ? pwm_out[c] : !pwm_out[c];
        if (a) act_n[c]++;
        if (a && !prev[c]) begin
          edg_n[c]++;
          if (c == 0 && edg_n[0] == 1) pos1 = k;
          if (c == 0 && edg_n[0] == 2) pos2 = k;
        end
        prev[c] = a;
      end
      if (mid && k == midk) begin
        bus_wr = 1'b1; bus_addr = ma; bus_wdata = md; bus_be = 2'b11;
      end else if (mid && k == midk + 1) begin
        bus_wr = 1'b0;
      end
    end
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(pwm_out == 2'b11, "R5 reset idle", int'(pwm_out), 3);
    br(2'd3, v);
    chk(v == 16'd0, "R6 reset counter", int'(v), 0);

    // Sweep over every time unit, cycle length and polarity setting.
    for (int cs = 0; cs < 2; cs++)
      for (int cy = 0; cy < 2; cy++)
        for (int os = 0; os < 2; os++) begin
          int n, da, db, t;
          string rq;
          n  = 1 << (W - ((cy != 0) ? LB : SB));
          t  = cs + 1;
          rq = (cs != 0) ? "R1" : "R2";
          for (int vi = 0; vi < 3; vi++) begin
            if (vi == 0) begin da = 0; db = MAXV; end
            else if (vi == 1) begin da = MAXV; db = 0; end
            else begin
              da = ((cs * 5 + cy * 3 + os * 7) * 37 + 11) % (MAXV + 1);
              db = MAXV - da - 3;
            end
            run_cfg(cs, cy, os, 1, 1, da, db);
            meas(cs, os, 0, 0, 2'd0, 16'd0);
            chk(act_n[0] == da * t, rq, act_n[0], da * t);
            chk(act_n[1] == db * t, rq, act_n[1], db * t);
          end
          da = 2; db = 3 * n + 5;
          run_cfg(cs, cy, os, 1, 1, da, db);
          meas(cs, os, 0, 0, 2'd0, 16'd0);
          chk(act_n[0] == da * t, "R2 code 2", act_n[0], da * t);
          chk(act_n[1] == db * t, "R2 mixed", act_n[1], db * t);
          chk(pos1 == 1, "R4 first extra unit", pos1, 1);
          chk(pos2 == (1 << (W - 1)) * t + 1, "R4 second extra unit", pos2, (1 << (W - 1)) * t + 1);
          chk(edg_n[1] == n, "R3 one run per basic cycle", edg_n[1], n);
        end

    // R4: code 1 is active only in the first time unit.
    run_cfg(0, 0, 1, 1, 1, 1, 1);
    meas(0, 1, 0, 0, 2'd0, 16'd0);
    chk(act_n[0] == 1 && pos1 == 1, "R4 code 1", pos1, 1);

    // R7: a mid-period write lands at the next period.
    run_cfg(0, 0, 0, 1, 1, 100, 200);
    meas(0, 0, 1, 300, 2'd1, 16'd700);
    chk(act_n[0] == 100, "R7 old code kept", act_n[0], 100);
    meas(0, 0, 0, 0, 2'd0, 16'd0);
    chk(act_n[0] == 700, "R7 new code", act_n[0], 700);
    chk(act_n[1] == 200, "R7 other channel", act_n[1], 200);

    // R5: a disabled channel stays idle under both polarities.
    run_cfg(0, 1, 1, 1, 0, 400, 500);
    meas(0, 1, 0, 0, 2'd0, 16'd0);
    chk(act_n[1] == 0, "R5 disabled high-active", act_n[1], 0);
    chk(act_n[0] == 400, "R5 enabled neighbour", act_n[0], 400);
    run_cfg(1, 0, 0, 0, 1, 600, 50);
    meas(1, 0, 0, 0, 2'd0, 16'd0);
    chk(act_n[0] == 0, "R5 disabled low-active", act_n[0], 0);
    chk(act_n[1] == 100, "R5 enabled neighbour", act_n[1], 100);

    // R8: counter load and readback.
    run_cfg(0, 0, 0, 1, 1, 10, 20);
    bw(2'd3, 16'(300 << SH), 2'b11);
    br(2'd3, v);
    chk(v == 16'(301 << SH), "R8 counter load", int'(v), 301 << SH);
    bw(2'd3, 16'd0, 2'b01);
    br(2'd3, v);
    chk(v == 16'(304 << SH), "R9 partial counter write", int'(v), 304 << SH);

    // R9: a partial write leaves the code registers unchanged.
    bw(2'd1, 16'h0155, 2'b11);
    bw(2'd1, 16'h00AA, 2'b01);
    br(2'd1, v);
    chk(v == 16'h0155, "R9 partial code write", int'(v), 16'h0155);
    bw(2'd2, 16'h0233, 2'b11);
    bw(2'd2, 16'h0011, 2'b10);
    br(2'd2, v);
    chk(v == 16'h0233, "R9 partial upper byte", int'(v), 16'h0233);

    // R10: read back the control word.
    bw(2'd0, 16'h002D, 2'b11);
    br(2'd0, v);
    chk(v == 16'h002D, "R10 control readback", int'(v), 16'h002D);

    // R6: stopping holds the counter at zero and idles both outputs.
    bw(2'd0, ctlw(0, 0, 1, 0, 1, 1), 2'b11);
    repeat (3) @(posedge clk);
    #1;
    chk(pwm_out == 2'b00, "R6 idle outputs", int'(pwm_out), 0);
    br(2'd3, v);
    chk(v == 16'd0, "R6 counter held", int'(v), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule